// File: doc/BRIEF.md
# Sync Pin Direction Resolver

This block decides whether a shared clock-synchronisation pin is driven by this converter or followed by it. An 8-bit configuration byte can be written and read back at any time. It selects one of four behaviours: sync off, drive the pin, follow the pin, or resolve the direction automatically. It also selects whether the rising or the falling pin edge is the active one. A write whose reserved low field is not the fixed pattern is refused, and a sticky flag is raised for the host.

In automatic mode the direction is settled once, when the converter enable input goes high. A pin already held high selects follow. A low pin is watched for a fixed window. If two successive active edges arrive closer together than four thirds of the nominal switching period, the block selects follow. If the window expires without that, it selects drive. In drive mode the block puts a square wave with the nominal period on the pin. In follow mode it emits a one-cycle pulse for each active pin edge.

The automatic-mode state machine has four states:
- ST_IDLE: unresolved.
- ST_DETECT: measuring the pin.
- ST_IN: resolved to follow.
- ST_OUT: resolved to drive.

Its transitions are:
- IDLE→IN on an enable rise with the pin high.
- IDLE→DETECT on an enable rise with the pin low.
- DETECT→IN on a fast period.
- DETECT→OUT when the window ends.
- Any state→IDLE when enable is low or the mode is not automatic.

Top module: `sync_dir_resolver`

## Requirements
- R1: After reset the configuration reads 8'h10, the invalid flag is 0, the resolved mode is 00, and the output enable and edge pulse are 0.
- R2: A write whose bits [4:0] equal 5'b10000 is stored and reads back unchanged from the next cycle. Bits [7:6] are the mode field and bit 5 is the edge select.
- R3: A write with any other bits [4:0] leaves the stored byte unchanged and sets the invalid flag. The flag stays set until a cycle with the clear input high and no invalid write.
- R4: Mode field values 00 (off), 01 (drive) and 10 (follow) appear on the resolved-mode output in the cycle after the write, whatever the enable input is doing.
- R5: In follow mode, each active pin edge gives one single-cycle pulse. A rising edge is active when bit 5 is 1, and a falling edge when bit 5 is 0. The pulse goes high on the second clock edge after the pin changes.
- R6: With mode 11, if enable rises while the synchronised pin is high, the resolved mode becomes 10 one cycle later.
- R7: With mode 11 and a low pin at enable, two active edges less than nominal_period*4/3 cycles apart within the window resolve to 10. A period of 26 with a nominal period of 20 qualifies.
- R8: With mode 11 and a low pin at enable, if no qualifying period is seen within DET_WIN cycles, the result is 01. This covers a period of 27 or 40 against a nominal 20, and a static pin.
- R9: With mode 11 the resolved mode reads 00 while detection runs and while enable is low. Dropping enable clears an earlier result.
- R10: When the resolved mode is 01, the output enable is 1 and the pin output is a square wave of nom_period cycles, high for nom_period/2 of them (nom_period >= 2).
- R11: With mode 00 the output enable and the edge pulse stay 0 regardless of pin activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration write byte |
| rd_data | output | 8 | Stored configuration byte |
| inv_clr | input | 1 | Clears the invalid-write flag |
| inv_flag | output | 1 | Sticky invalid-write flag |
| conv_en | input | 1 | Converter enable condition |
| sync_pin | input | 1 | Asynchronous digital level of the sync pin |
| nom_period | input | PW | Nominal switching period in clock cycles |
| mode_res | output | 2 | Resolved mode: 00 off, 01 drive, 10 follow |
| edge_rise | output | 1 | Selected active edge, 1 = rising |
| sync_pulse | output | 1 | One-cycle pulse per active edge in follow mode |
| sync_oe | output | 1 | Pin output enable |
| sync_out | output | 1 | Square wave driven onto the pin |

## Verification
The bench probes the rate threshold from both sides with periods of 26 and 27 cycles against a nominal 20. A comparator that is off by one, or that uses the wrong fraction, would resolve one of them the wrong way. It writes bytes with a bad reserved field and clears the flag around them, which catches a design that stores refused bytes or lets the flag lapse. It toggles the pin in off mode and with the non-selected polarity; a leaky edge path would then show extra pulses. Finally, it drops and re-raises enable, which exposes a result that survives across enables or is re-decided mid-run.

// File: rtl/sync_dir_pkg.sv
`timescale 1ns/1ps
package sync_dir_pkg;
    typedef enum logic [1:0] {
        SM_OFF  = 2'b00,
        SM_OUT  = 2'b01,
        SM_IN   = 2'b10,
        SM_AUTO = 2'b11
    } sync_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DETECT,
        ST_IN,
        ST_OUT
    } det_state_e;

    localparam logic [4:0] RSVD_PATTERN = 5'b10000;
    localparam logic [7:0] CFG_DEFAULT  = {2'b00, 1'b0, RSVD_PATTERN};
endpackage

// File: rtl/sync_cfg_reg.sv
`timescale 1ns/1ps
module sync_cfg_reg
    import sync_dir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       inv_clr,
    output logic [7:0] cfg_q,
    output logic       inv_flag
);
    logic bad_wr;
    assign bad_wr = wr_en && (wr_data[4:0] != RSVD_PATTERN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= CFG_DEFAULT;
            inv_flag <= 1'b0;
        end else begin
            if (wr_en && !bad_wr)
                cfg_q <= wr_data;
            if (bad_wr)
                inv_flag <= 1'b1;
            else if (inv_clr)
                inv_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/sync_edge_det.sv
`timescale 1ns/1ps
module sync_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic rise_sel,
    output logic lvl,
    output logic edge_p
);
    logic [STAGES-1:0] chain;
    logic              lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            lvl_q <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin_async};
            lvl_q <= chain[STAGES-1];
        end
    end

    assign lvl    = chain[STAGES-1];
    assign edge_p = rise_sel ? (lvl & ~lvl_q) : (~lvl & lvl_q);
endmodule

// File: rtl/sync_sqwave.sv
`timescale 1ns/1ps
module sync_sqwave #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] period,
    output logic          wave
);
    logic [PW-1:0] cnt;
    logic [PW-1:0] half;

    assign half = {1'b0, period[PW-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt >= period - PW'(1))
            cnt <= '0;
        else
            cnt <= cnt + PW'(1);
    end

    assign wave = run && (cnt < half);
endmodule

// File: rtl/sync_dir_resolver.sv
`timescale 1ns/1ps
module sync_dir_resolver
    import sync_dir_pkg::*;
#(
    parameter int PW      = 8,
    parameter int DET_WIN = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data,
    input  logic          inv_clr,
    output logic          inv_flag,
    input  logic          conv_en,
    input  logic          sync_pin,
    input  logic [PW-1:0] nom_period,
    output logic [1:0]    mode_res,
    output logic          edge_rise,
    output logic          sync_pulse,
    output logic          sync_oe,
    output logic          sync_out
);
    localparam int CW = PW + 2;
    localparam int MW = PW + 4;
    localparam int WW = $clog2(DET_WIN);

    logic [7:0]    cfg_q;
    sync_mode_e    cfg_mode;
    logic          pin_lvl, edge_raw;
    det_state_e    state, nxt;
    logic          en_q;
    logic [CW-1:0] per_cnt;
    logic          have_edge;
    logic [WW-1:0] win_cnt;
    logic [MW-1:0] per3, nom4;
    logic          fast_hit, win_done;
    sync_mode_e    res;

    sync_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .inv_clr(inv_clr), .cfg_q(cfg_q), .inv_flag(inv_flag)
    );

    assign rd_data   = cfg_q;
    assign cfg_mode  = sync_mode_e'(cfg_q[7:6]);
    assign edge_rise = cfg_q[5];

    sync_edge_det #(.STAGES(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_async(sync_pin),
        .rise_sel(cfg_q[5]), .lvl(pin_lvl), .edge_p(edge_raw)
    );

    // period measurement between successive active edges
    assign per3     = {2'b00, per_cnt} + {1'b0, per_cnt, 1'b0};
    assign nom4     = {2'b00, nom_period, 2'b00};
    assign fast_hit = edge_raw && have_edge && (per3 < nom4);
    assign win_done = (win_cnt == WW'(DET_WIN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_cnt   <= '0;
            have_edge <= 1'b0;
            win_cnt   <= '0;
        end else if (state == ST_DETECT) begin
            win_cnt <= win_cnt + WW'(1);
            if (edge_raw) begin
                per_cnt   <= CW'(1);
                have_edge <= 1'b1;
            end else if (per_cnt != {CW{1'b1}}) begin
                per_cnt <= per_cnt + CW'(1);
            end
        end else begin
            per_cnt   <= '0;
            have_edge <= 1'b0;
            win_cnt   <= '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            en_q  <= 1'b0;
        end else begin
            state <= nxt;
            en_q  <= conv_en;
        end
    end

    always_comb begin
        nxt = state;
        if (!conv_en || cfg_mode != SM_AUTO) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (!en_q) nxt = pin_lvl ? ST_IN : ST_DETECT;
                ST_DETECT: if (fast_hit) nxt = ST_IN;
                           else if (win_done) nxt = ST_OUT;
                ST_IN:     nxt = ST_IN;
                ST_OUT:    nxt = ST_OUT;
            endcase
        end
    end

    // outputs
    always_comb begin
        if (cfg_mode != SM_AUTO) begin
            res = cfg_mode;
        end else begin
            unique case (state)
                ST_IN:   res = SM_IN;
                ST_OUT:  res = SM_OUT;
                ST_IDLE,
                ST_DETECT: res = SM_OFF;
            endcase
        end
    end

    assign mode_res   = res;
    assign sync_oe    = (res == SM_OUT);
    assign sync_pulse = edge_raw && (res == SM_IN);

    sync_sqwave #(.PW(PW)) u_sq (
        .clk(clk), .rst_n(rst_n), .run(res == SM_OUT),
        .period(nom_period), .wave(sync_out)
    );
endmodule

// File: rtl/sync_dir_resolver_chk.sv
`timescale 1ns/1ps
module sync_dir_resolver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       inv_clr,
    input logic       inv_flag,
    input logic       conv_en,
    input logic [1:0] mode_res,
    input logic       sync_pulse,
    input logic       sync_oe,
    input logic       sync_out
);
    // R2
    valid_wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[4:0] == 5'b10000 |=> rd_data == $past(wr_data));

    // R3
    bad_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[4:0] != 5'b10000 |=> $stable(rd_data) && inv_flag);

    // R3
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_clr && !(wr_en && wr_data[4:0] != 5'b10000) |=> !inv_flag);

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse);

    // R5
    pulse_in_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> mode_res == 2'b10);

    // R10
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_oe |-> !sync_out);

    // R11
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b00 |-> !sync_pulse && !sync_oe && mode_res == 2'b00);

    // R9
    unresolved_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b11 && !$past(conv_en) |-> mode_res == 2'b00);
endmodule

bind sync_dir_resolver sync_dir_resolver_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .inv_clr(inv_clr), .inv_flag(inv_flag),
    .conv_en(conv_en), .mode_res(mode_res), .sync_pulse(sync_pulse),
    .sync_oe(sync_oe), .sync_out(sync_out)
);

// File: tb/sync_dir_resolver_bench.sv
`timescale 1ns/1ps
module sync_dir_resolver_bench;
    localparam int PW      = 8;
    localparam int DET_WIN = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          inv_clr = 1'b0;
    logic          inv_flag;
    logic          conv_en = 1'b0;
    logic          sync_pin = 1'b0;
    logic [PW-1:0] nom_period = 8'd20;
    logic [1:0]    mode_res;
    logic          edge_rise;
    logic          sync_pulse;
    logic          sync_oe;
    logic          sync_out;

    int checks = 0;
    int failures = 0;
    int pulse_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_dir_resolver #(.PW(PW), .DET_WIN(DET_WIN)) u_sync_dir_resolver (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .inv_clr(inv_clr), .inv_flag(inv_flag),
        .conv_en(conv_en), .sync_pin(sync_pin), .nom_period(nom_period),
        .mode_res(mode_res), .edge_rise(edge_rise), .sync_pulse(sync_pulse),
        .sync_oe(sync_oe), .sync_out(sync_out)
    );

    always @(negedge clk) if (sync_pulse) pulse_cnt++;

    // {wdata, expected rd, expected mode, expected flag, clear first}
    localparam logic [19:0] VEC [6] = '{
        {8'h50, 8'h50, 2'b01, 1'b0, 1'b0},
        {8'h51, 8'h50, 2'b01, 1'b1, 1'b0},
        {8'hB0, 8'hB0, 2'b10, 1'b1, 1'b0},
        {8'h80, 8'hB0, 2'b10, 1'b1, 1'b1},
        {8'h30, 8'h30, 2'b00, 1'b0, 1'b1},
        {8'hF0, 8'hF0, 2'b00, 1'b0, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        inv_clr = 1'b1;
        tick();
        inv_clr = 1'b0;
    endtask

    task automatic toggle(input int per, input int n);
        for (int i = 0; i < n; i++) begin
            sync_pin = 1'b1; tick(per / 2);
            sync_pin = 1'b0; tick(per - per / 2);
        end
    endtask

    task automatic auto_run(input int per, input int n, input int exp_mode, input string req);
        conv_en = 1'b0; sync_pin = 1'b0; tick(5);
        conv_en = 1'b1; tick();
        check({req, " detecting reads off (R9)"}, mode_res, 0);
        toggle(per, n);
        tick(DET_WIN + 10);
        check(req, mode_res, exp_mode);
        conv_en = 1'b0; tick();
    endtask

    initial begin
        int base;
        int highs;
        tick(4);
        rst_n = 1'b1;
        tick();
        check("R1 rd_data", rd_data, 8'h10);
        check("R1 inv_flag", inv_flag, 0);
        check("R1 mode_res", mode_res, 0);
        check("R1 sync_oe", sync_oe, 0);
        check("R1 sync_pulse", sync_pulse, 0);

        foreach (VEC[i]) begin
            if (VEC[i][0]) pulse_clr();
            write_cfg(VEC[i][19:12]);
            check("R2/R3 rd_data", rd_data, VEC[i][11:4]);
            check("R4/R9 mode_res", mode_res, VEC[i][3:2]);
            check("R3 inv_flag", inv_flag, VEC[i][1]);
        end

        // R5 rising edge, latency and single pulse
        write_cfg(8'hB0);
        tick(3);
        check("R5 edge_rise", edge_rise, 1);
        sync_pin = 1'b1; tick();
        check("R5 no pulse after one edge", sync_pulse, 0);
        tick();
        check("R5 pulse at second edge", sync_pulse, 1);
        tick();
        check("R5 pulse one cycle", sync_pulse, 0);
        base = pulse_cnt;
        sync_pin = 1'b0; tick(5);
        check("R5 falling ignored when rising selected", pulse_cnt - base, 0);
        write_cfg(8'h90);
        base = pulse_cnt;
        sync_pin = 1'b1; tick(5);
        sync_pin = 1'b0; tick(5);
        check("R5 falling edge pulses", pulse_cnt - base, 1);

        // R11 off mode
        write_cfg(8'h30);
        base = pulse_cnt;
        toggle(6, 4);
        tick(4);
        check("R11 no pulse", pulse_cnt - base, 0);
        check("R11 no oe", sync_oe, 0);

        // R10 square wave
        write_cfg(8'h50);
        check("R10 oe", sync_oe, 1);
        tick(3);
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            if (sync_out) highs++;
            tick();
        end
        check("R10 high cycles in two periods", highs, 20);

        // R6 static high at enable
        write_cfg(8'hF0);
        sync_pin = 1'b1; tick(5);
        check("R9 auto with enable low", mode_res, 0);
        conv_en = 1'b1; tick();
        check("R6 pin high selects follow", mode_res, 2);
        conv_en = 1'b0; tick();
        check("R9 enable drop clears", mode_res, 0);

        auto_run(20, 0, 1, "R8 static low selects drive");
        check("R10 oe after drive resolve", sync_oe, 0);
        auto_run(20, 4, 2, "R7 period 20 selects follow");
        auto_run(26, 4, 2, "R7 period 26 selects follow");
        auto_run(27, 42, 1, "R8 period 27 selects drive");
        auto_run(40, 28, 1, "R8 period 40 selects drive");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule